// File: doc/BRIEF.md
# Single-Port SRAM Queue Controller

This block runs a first-in first-out queue of 16-bit words whose storage is one external asynchronous SRAM that has a single port. The controller clock runs several times faster than the user request rate. Read and write traffic therefore share the one SRAM port in short access slots. A read slot lasts two clocks and a write slot lasts three. The write strobe is pulsed only in the middle clock of a write slot, so address and data are settled before the strobe falls and are still held after it rises.

Two address counters, one for writes and one for reads, feed an address register. That register is loaded only at the start of a slot. While no access is under way, the address bus does not toggle. An occupancy counter tracks the number of accepted words and drives the empty, full and half-full flags. The oldest word is fetched ahead of time into an output register, so a read is served in the same cycle it is requested. The fetch is then refilled in the background.

Requests are single-cycle pulses, and successive requests must be at least 8 controller clocks apart. A write and a read may be issued in the same cycle.

Top module: `sqTop`

## Requirements
- R1: A synchronous active-high reset empties the queue. After reset, empty is 1, full, halfFull, overflow and underflow are 0, and sramCeN, sramOeN and sramWeN are all 1.
- R2: When empty is 0 and at least 8 clocks have passed since the last request, rdData shows the oldest stored word. A read pulse removes that word.
- R3: The flags come from the occupancy count. empty means the count is 0, full means it equals 2^ADDR_W, and halfFull means it is at least 2^(ADDR_W-1). An accepted write and an accepted read in the same cycle leave the count unchanged.
- R4: A write request while full is ignored, so the count and stored data stay the same. overflow is 1 for exactly the following cycle.
- R5: A read request while empty is ignored. underflow is 1 for exactly the following cycle.
- R6: A read slot holds sramCeN and sramOeN low for exactly 2 consecutive clocks, with sramWeN high.
- R7: A write slot holds sramCeN low and sramDoutEn high for 3 clocks, with sramOeN high. sramWeN is low only in the middle clock, and never for two clocks in a row.
- R8: sramAddr changes only in the cycle where sramCeN falls. It is stable inside every slot and between slots.
- R9: When the output register is empty and a word is waiting in SRAM, the fetch is served before a pending write. With a write and a read in the same cycle, the first slot that follows is a read slot (sramOeN low 2 clocks after the request edge). A write alone starts a write slot at that point (sramCeN low, sramOeN high).
- R10: Both address counters wrap at 2^ADDR_W, and data order is kept across the wrap.
- R11: With a write and a read together, a full queue accepts the read and rejects the write. An empty queue accepts the write and rejects the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| wrReq | input | 1 | Write request pulse |
| wrData | input | DATA_W | Word to store |
| rdReq | input | 1 | Read (pop) request pulse |
| rdData | output | DATA_W | Oldest word, held in output register |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals SRAM depth |
| halfFull | output | 1 | Occupancy at least half the depth |
| overflow | output | 1 | One-cycle pulse after a rejected write |
| underflow | output | 1 | One-cycle pulse after a rejected read |
| sramAddr | output | ADDR_W | SRAM address |
| sramDout | output | DATA_W | Data toward SRAM |
| sramDoutEn | output | 1 | Drive enable for sramDout |
| sramDin | input | DATA_W | Data from SRAM |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |

## Verification
A pop of the output register and the acceptance of a new write can fall in the same cycle. After such a cycle, the refill fetch and the pending write compete for the next SRAM slot. The bench issues both requests together at several fill levels: empty, full, and in between. A reference queue, advanced on every clock, judges the flags, the error pulses and the word delivered. A strobe monitor confirms that the read slot comes first and that the write slot then follows with a correct strobe shape.

// File: rtl/sqPkg.sv
package sqPkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD0  = 3'd1,
    S_RD1  = 3'd2,
    S_WR0  = 3'd3,
    S_WR1  = 3'd4,
    S_WR2  = 3'd5
  } sqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldRdAddr;   // load read pointer into address register
    logic ldWrAddr;   // load write pointer into address register
    logic ldWrData;   // capture user write word
    logic capRead;    // capture SRAM word into output register
    logic finWrite;   // write slot done, advance write pointer
    logic driveData;  // enable data toward SRAM
  } sqStrobe_t;
endpackage

// File: rtl/sqCtrl.sv
module sqCtrl
  import sqPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wrReq,
  input  logic      rdReq,
  output sqStrobe_t stb,
  output logic      empty,
  output logic      full,
  output logic      halfFull,
  output logic      overflow,
  output logic      underflow,
  output logic      sramCeN,
  output logic      sramOeN,
  output logic      sramWeN
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [CNT_W-1:0] CNT_HALF = {2'b01, {(ADDR_W-1){1'b0}}};

  sqState_t         state, nextState;
  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] avail;
  logic             outValid;
  logic             wrPending;
  logic             wrOk, rdOk, needFetch;

  assign empty    = (occ == '0);
  assign full     = (occ == CNT_FULL);
  assign halfFull = (occ >= CNT_HALF);
  assign wrOk     = wrReq && !full;
  assign rdOk     = rdReq && !empty;

  // words resident in SRAM that are not yet fetched
  assign avail     = occ - CNT_W'(outValid) - CNT_W'(wrPending);
  assign needFetch = !outValid && (avail != '0);

  always_comb begin
    nextState    = state;
    stb          = '0;
    stb.ldWrData = wrOk;
    case (state)
      S_IDLE: begin
        if (needFetch) begin
          nextState    = S_RD0;
          stb.ldRdAddr = 1'b1;
        end else if (wrPending) begin
          nextState    = S_WR0;
          stb.ldWrAddr = 1'b1;
        end
      end
      S_RD0: nextState = S_RD1;
      S_RD1: begin
        nextState   = S_IDLE;
        stb.capRead = 1'b1;
      end
      S_WR0: begin
        nextState     = S_WR1;
        stb.driveData = 1'b1;
      end
      S_WR1: begin
        nextState     = S_WR2;
        stb.driveData = 1'b1;
      end
      S_WR2: begin
        nextState     = S_IDLE;
        stb.driveData = 1'b1;
        stb.finWrite  = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign sramCeN = (state == S_IDLE);
  assign sramOeN = !((state == S_RD0) || (state == S_RD1));
  assign sramWeN = (state != S_WR1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      occ       <= '0;
      outValid  <= 1'b0;
      wrPending <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      state     <= nextState;
      occ       <= occ + CNT_W'(wrOk) - CNT_W'(rdOk);
      overflow  <= wrReq && full;
      underflow <= rdReq && empty;
      if (wrOk)
        wrPending <= 1'b1;
      else if (state == S_WR2)
        wrPending <= 1'b0;
      if (rdOk)
        outValid <= 1'b0;
      else if (state == S_RD1)
        outValid <= 1'b1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (empty && !full && sramCeN && sramWeN && sramOeN && !overflow && !underflow));
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_FULL);
  a_r4_ovf_pulse: assert property (@(posedge clk) disable iff (rst)
    (wrReq && full) |=> overflow);
  a_r4_full_kept: assert property (@(posedge clk) disable iff (rst)
    (full && wrReq && !rdReq) |=> full);
  a_r5_udf_pulse: assert property (@(posedge clk) disable iff (rst)
    (rdReq && empty) |=> underflow);
  a_r5_empty_kept: assert property (@(posedge clk) disable iff (rst)
    (empty && rdReq && !wrReq) |=> empty);
  a_r6_read_two: assert property (@(posedge clk) disable iff (rst)
    $fell(sramOeN) |=> (!sramOeN && sramWeN));
  a_r7_we_inside: assert property (@(posedge clk) disable iff (rst)
    !sramWeN |-> (!sramCeN && sramOeN));
  a_r7_we_single: assert property (@(posedge clk) disable iff (rst)
    !sramWeN |=> sramWeN);
endmodule

// File: rtl/sqDatapath.sv
module sqDatapath
  import sqPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  sqStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] sramDin,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoutEn
);
  logic [ADDR_W-1:0] rdPtr, wrPtr, addrQ;
  logic [DATA_W-1:0] wrWord, outWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      addrQ   <= '0;
      wrWord  <= '0;
      outWord <= '0;
    end else begin
      if (stb.ldRdAddr)
        addrQ <= rdPtr;
      else if (stb.ldWrAddr)
        addrQ <= wrPtr;
      if (stb.ldWrData)
        wrWord <= wrData;
      if (stb.capRead) begin
        outWord <= sramDin;
        rdPtr   <= rdPtr + 1'b1;
      end
      if (stb.finWrite)
        wrPtr <= wrPtr + 1'b1;
    end
  end

  assign sramAddr   = addrQ;
  assign sramDout   = wrWord;
  assign sramDoutEn = stb.driveData;
  assign rdData     = outWord;

  a_r10_write_data_held: assert property (@(posedge clk) disable iff (rst)
    (stb.driveData && !stb.finWrite) |=> $stable(sramDout));
endmodule

// File: rtl/sqTop.sv
module sqTop
  import sqPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              full,
  output logic              halfFull,
  output logic              overflow,
  output logic              underflow,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoutEn,
  input  logic [DATA_W-1:0] sramDin,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN
);
  sqStrobe_t stb;

  sqCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .wrReq(wrReq), .rdReq(rdReq), .stb(stb),
    .empty(empty), .full(full), .halfFull(halfFull),
    .overflow(overflow), .underflow(underflow),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN)
  );

  sqDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .sramDin(sramDin),
    .rdData(rdData), .sramAddr(sramAddr), .sramDout(sramDout),
    .sramDoutEn(sramDoutEn)
  );

  a_r8_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    !$fell(sramCeN) |-> $stable(sramAddr));
  a_r7_drive_no_oe: assert property (@(posedge clk) disable iff (rst)
    sramDoutEn |-> (sramOeN && !sramCeN));
endmodule

// File: tb/sim_sqTop.sv
module sim_sqTop;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrReq = 1'b0, rdReq = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData, sramDout, sramDin;
  logic          empty, full, halfFull, overflow, underflow;
  logic [AW-1:0] sramAddr;
  logic          sramDoutEn, sramCeN, sramOeN, sramWeN;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sqTop #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .wrReq(wrReq), .wrData(wrData), .rdReq(rdReq),
    .rdData(rdData), .empty(empty), .full(full), .halfFull(halfFull),
    .overflow(overflow), .underflow(underflow), .sramAddr(sramAddr),
    .sramDout(sramDout), .sramDoutEn(sramDoutEn), .sramDin(sramDin),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN)
  );

  // behavioural SRAM
  logic [DW-1:0] mem [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  always @(posedge sramWeN) if (!sramCeN && sramDoutEn) mem[sramAddr] <= sramDout;
  assign sramDin = mem[sramAddr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference queue, advanced every clock
  logic [DW-1:0] q[$];
  bit expOvf = 0, expUdf = 0;
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      expOvf = 0;
      expUdf = 0;
    end else begin
      bit isFull, isEmpty;
      isFull  = (q.size() == DEPTH);
      isEmpty = (q.size() == 0);
      expOvf  = wrReq && isFull;
      expUdf  = rdReq && isEmpty;
      if (rdReq && !isEmpty) void'(q.pop_front());
      if (wrReq && !isFull) q.push_back(wrData);
    end
  end

  // per-cycle monitor of flags and strobes
  bit   prevWeLow = 0, prevCe = 1;
  int   oeRun = 0;
  logic [AW-1:0] prevAddr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(empty == (q.size() == 0), "R3 empty", empty, q.size() == 0);
      chk(full == (q.size() == DEPTH), "R3 full", full, q.size() == DEPTH);
      chk(halfFull == (q.size() >= DEPTH / 2), "R3 halfFull", halfFull, q.size() >= DEPTH / 2);
      chk(overflow == expOvf, "R4 overflow", overflow, expOvf);
      chk(underflow == expUdf, "R5 underflow", underflow, expUdf);
      if (!sramWeN) begin
        chk(!prevWeLow, "R7 we width", 2, 1);
        chk(!sramCeN && sramOeN && sramDoutEn, "R7 we framing",
            {sramCeN, sramOeN, sramDoutEn}, 3'b011);
      end
      if (!sramOeN) begin
        oeRun++;
        chk(sramWeN && !sramCeN, "R6 read strobes", {sramWeN, sramCeN}, 2'b10);
      end else begin
        if (oeRun != 0) chk(oeRun == 2, "R6 read length", oeRun, 2);
        oeRun = 0;
      end
      if (!(prevCe && !sramCeN))
        chk(sramAddr == prevAddr, "R8 address quiet", sramAddr, prevAddr);
    end
    prevWeLow = !sramWeN;
    prevCe    = sramCeN;
    prevAddr  = sramAddr;
  end

  // one request period of 8 clocks
  task automatic op(input bit w, input bit r, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    if (r && q.size() > 0) chk(rdData == q[0], tag, rdData, q[0]);
    wrReq = w; rdReq = r; wrData = d;
    @(negedge clk);
    wrReq = 0; rdReq = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held by reset
    chk(empty && !full && !halfFull && !overflow && !underflow, "R1 flags",
        {empty, full, halfFull, overflow, underflow}, 5'b10000);
    chk(sramCeN && sramOeN && sramWeN, "R1 strobes", {sramCeN, sramOeN, sramWeN}, 3'b111);
    rst = 0;

    op(0, 1, 16'h0, "R5 read on empty");
    for (int i = 0; i < 5; i++) op(1, 0, 16'hA000 + 16'(i), "R2");
    for (int i = 0; i < 3; i++) op(0, 1, 16'h0, "R2 order");
    // fill to full, pointers pass the wrap point (R10)
    while (q.size() < DEPTH) op(1, 0, 16'hB000 + 16'(q.size()), "R3");
    op(1, 0, 16'hDEAD, "R4 write on full");
    op(1, 1, 16'hBEEF, "R11 full both");   // read taken, write rejected
    chk(q.size() == DEPTH - 1, "R11 full both size", q.size(), DEPTH - 1);

    // R9: read and write together, refill fetch comes first
    @(negedge clk);
    chk(rdData == q[0], "R9 data", rdData, q[0]);
    wrReq = 1; rdReq = 1; wrData = 16'hC001;
    @(negedge clk); wrReq = 0; rdReq = 0;
    @(negedge clk);
    chk(!sramOeN && !sramCeN, "R9 fetch first", {sramOeN, sramCeN}, 2'b00);
    repeat (5) @(negedge clk);
    // R9: write alone with valid output register starts a write slot
    @(negedge clk);
    wrReq = 0; rdReq = 1;
    @(negedge clk); rdReq = 0;
    repeat (6) @(negedge clk);
    @(negedge clk);
    wrReq = 1; wrData = 16'hC002;
    @(negedge clk); wrReq = 0;
    @(negedge clk);
    chk(!sramCeN && sramOeN, "R9 write slot", {sramCeN, sramOeN}, 2'b01);
    repeat (5) @(negedge clk);

    // drain across wrap (R10)
    while (q.size() > 0) op(0, 1, 16'h0, "R10 wrap order");
    op(1, 1, 16'hE001, "R11 empty both");  // write taken, read rejected
    chk(q.size() == 1, "R11 empty both size", q.size(), 1);

    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      op(sel < 5 || sel == 9, sel >= 4, 16'($urandom), "R2 random");
    end
    while (q.size() > 0) op(0, 1, 16'h0, "R2 drain");
    finish_run();
  end
endmodule